// File: doc/BRIEF.md
# IDE I/O Window Address Router

This block sits behind the programmed-I/O port of a two-channel disk controller. Each host byte address is compared against five windows, each with a programmable base and a fixed size. There is a command window and a control window for each of the two channels, plus one shared window for the bus-master registers. The block reports which kind of window was hit, the offset inside it, and whether the access belongs to the first or the second channel.

Each channel has a one-bit shadow of the drive-select bit. The shadow is captured whenever the host writes the drive-select register in that channel's command window. With it, every access is steered to one of four drive slots. A presence mask tells the block which slots hold a drive. Accesses that hit no window, or that use a width the target window does not allow, are flagged as errors.

The decode is combinational. Its result is registered once and presented with a one-cycle valid strobe.

Top module: `ide_io_router`

## Requirements
- R1: Window index 0 is the first-channel command window, 1 the first-channel control window, 2 the second-channel command window, 3 the second-channel control window and 4 the bus-master window. The type output is encoded as command=0, control=1, bus-master=2 and no-window=3.
- R2: For a matching access, the offset output equals the address minus the base of the matching window.
- R3: In the bus-master window, offsets below 8 report the first channel (secondary flag 0). Offsets of 8 and above report the second channel (secondary flag 1).
- R4: An address inside no window gives type 3, offset 0, secondary flag 0, drive 0, and raises the error flag.
- R5: A base write with value zero leaves that window unchanged. A window that has never received a nonzero base matches no address.
- R6: A write to offset 6 of a channel's command window, if it has no error, captures data bit 4 into that channel's shadow. The shadow resets to 0.
- R7: The drive index is the channel's shadow bit for the first channel, and 2 plus the shadow bit for the second channel. On the drive-select write itself, the newly written bit is used.
- R8: Size code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is invalid. Code 3 is an error in any window, and a 4-byte access to a command or control window is an error. An access with an error does not change any shadow.
- R9: The result of an access appears with exactly one cycle of latency, and the valid strobe is high for one cycle per request.
- R10: When windows overlap, the lowest-numbered matching window wins.
- R11: The drive-ok output is high only when the access has no error and the presence-mask bit of the selected drive slot is set.
- R12: After reset the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Base write strobe |
| cfg_idx | input | 3 | Window index for the base write (0..4) |
| cfg_base | input | AW | New base value; zero is ignored |
| req_vld | input | 1 | Access request strobe |
| req_addr | input | AW | Access byte address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_data | input | 8 | Low write-data byte |
| drv_present | input | 4 | One bit per drive slot, set when a drive is attached |
| rsp_vld | output | 1 | One-cycle result strobe |
| rsp_type | output | 2 | Window type of the access |
| rsp_off | output | OW | Window-relative offset |
| rsp_sec | output | 1 | Access belongs to the second channel |
| rsp_err | output | 1 | Illegal access |
| rsp_drive | output | 2 | Target drive slot |
| rsp_drv_ok | output | 1 | Target slot is populated and the access is legal |

## Verification
The assertions assume that `cfg_idx` addresses an existing window whenever `cfg_we` is high. They also assume that a request and a base write never arrive in the same cycle, so every decode sees settled bases. The stimulus programs all bases in separate cycles before the request table runs. It later moves the bus-master base only between requests. The drive-select data is chosen so that bit 4 alternates and the other bits vary, which shows that only the documented bit is captured.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;

  localparam int NWIN = 5;

  typedef enum logic [1:0] {
    WT_CMD  = 2'd0,
    WT_CTRL = 2'd1,
    WT_BM   = 2'd2,
    WT_NONE = 2'd3
  } win_type_e;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  // window index -> kind (R1)
  function automatic win_type_e kind_of(input int i);
    if (i == NWIN - 1) return WT_BM;
    else if (i % 2 == 0) return WT_CMD;
    else return WT_CTRL;
  endfunction

  // fixed channel of the per-channel windows (R1)
  function automatic logic chan_of(input int i);
    return (i == 2) || (i == 3);
  endfunction

endpackage

// File: rtl/ide_rt_winbank.sv
module ide_rt_winbank
  import ide_rt_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CMD_SZ  = 8,
  parameter int CTRL_SZ = 4,
  parameter int BM_SZ   = 16,
  parameter int OW      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_idx,
  input  logic [AW-1:0]            cfg_base,
  input  logic [AW-1:0]            addr,
  output logic [NWIN-1:0]          hit,
  output logic [NWIN-1:0][OW-1:0]  off
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int SZI = (g == NWIN - 1) ? BM_SZ : ((g % 2 == 0) ? CMD_SZ : CTRL_SZ);
    localparam logic [AW-1:0] SZ = AW'(SZI);

    logic [AW-1:0] base_q, base_d;
    logic          armed_q, armed_d;
    logic          load;
    logic [AW-1:0] diff;

    // next state
    always_comb begin
      load    = cfg_we && (cfg_idx == 3'(g)) && (cfg_base != '0);
      base_d  = load ? cfg_base : base_q;
      armed_d = armed_q | load;
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        armed_q <= 1'b0;
      end else if (load) begin
        base_q  <= base_d;
        armed_q <= armed_d;
      end
    end

    // match
    always_comb begin
      diff   = addr - base_q;
      hit[g] = armed_q && (addr >= base_q) && (diff < SZ);
      off[g] = diff[OW-1:0];
    end

    assert_zero_base_ignored_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == 3'(g) && cfg_base == '0) |=> $stable(base_q)
    );

    assert_base_taken_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == 3'(g) && cfg_base != '0) |=> (base_q == $past(cfg_base) && armed_q)
    );

    assert_unarmed_no_hit_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      !armed_q |-> !hit[g]
    );
  end

endmodule

// File: rtl/ide_rt_select.sv
module ide_rt_select
  import ide_rt_pkg::*;
#(
  parameter int OW       = 4,
  parameter int BM_SPLIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWIN-1:0]          hit,
  input  logic [NWIN-1:0][OW-1:0]  off,
  input  logic [1:0]               size,
  output win_type_e                kind,
  output logic [OW-1:0]            offset,
  output logic                     sec,
  output logic                     size_err,
  output logic                     any_hit
);

  localparam logic [OW-1:0] SPLIT = OW'(BM_SPLIT);

  logic [2:0] sel;

  // lowest index wins (R10)
  always_comb begin
    sel = 3'd0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) sel = 3'(i);
    end
  end

  always_comb begin
    any_hit = |hit;
    kind    = WT_NONE;
    offset  = '0;
    sec     = 1'b0;
    if (any_hit) begin
      kind   = kind_of(int'(sel));
      offset = off[sel];
      if (kind == WT_BM) sec = (offset >= SPLIT);   // R3
      else               sec = chan_of(int'(sel));
    end
    size_err = (size == SZ_BAD) || (size == SZ_B4 && kind != WT_BM);
  end

  assert_lowest_wins_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit[sel] && ((hit & ((NWIN'(1) << sel) - NWIN'(1))) == '0))
  );

  assert_wide_cmd_err_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (size == SZ_B4 && (kind == WT_CMD || kind == WT_CTRL)) |-> size_err
  );

endmodule

// File: rtl/ide_rt_shadow.sv
module ide_rt_shadow
  import ide_rt_pkg::*;
#(
  parameter int OW      = 4,
  parameter int SEL_OFF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  win_type_e     acc_kind,
  input  logic [OW-1:0] acc_off,
  input  logic          acc_sec,
  input  logic          acc_err,
  input  logic          dev_bit,
  output logic [1:0]    drive
);

  logic [1:0] dev_q, dev_d;
  logic       latch;
  logic       cur;

  // next state
  always_comb begin
    latch = acc_vld && acc_wr && !acc_err && (acc_kind == WT_CMD) &&
            (acc_off == OW'(SEL_OFF));
    dev_d = dev_q;
    if (latch) dev_d[acc_sec] = dev_bit;
    cur   = latch ? dev_bit : dev_q[acc_sec];
    drive = (acc_kind == WT_NONE) ? 2'd0 : {acc_sec, cur};   // R7
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_q <= 2'b00;
    else if (latch) dev_q <= dev_d;
  end

  assert_shadow_capture_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    latch |=> (dev_q[$past(acc_sec)] == $past(dev_bit))
  );

  assert_shadow_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(dev_q)
  );

endmodule

// File: rtl/ide_io_router.sv
module ide_io_router
  import ide_rt_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMD_SZ   = 8,
  parameter int CTRL_SZ  = 4,
  parameter int BM_SZ    = 16,
  parameter int BM_SPLIT = 8,
  parameter int SEL_OFF  = 6,
  parameter int DEV_BIT  = 4,
  parameter int OW       = $clog2((BM_SZ > CMD_SZ) ? ((BM_SZ > CTRL_SZ) ? BM_SZ : CTRL_SZ)
                                                   : ((CMD_SZ > CTRL_SZ) ? CMD_SZ : CTRL_SZ))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [1:0]    req_size,
  input  logic [7:0]    req_data,
  input  logic [3:0]    drv_present,
  output logic          rsp_vld,
  output logic [1:0]    rsp_type,
  output logic [OW-1:0] rsp_off,
  output logic          rsp_sec,
  output logic          rsp_err,
  output logic [1:0]    rsp_drive,
  output logic          rsp_drv_ok
);

  logic [NWIN-1:0]         hit;
  logic [NWIN-1:0][OW-1:0] woff;
  win_type_e               kind;
  logic [OW-1:0]           offset;
  logic                    sec, size_err, any_hit, err;
  logic [1:0]              drive;
  logic                    unused_data;

  assign unused_data = ^req_data;

  ide_rt_winbank #(
    .AW(AW), .CMD_SZ(CMD_SZ), .CTRL_SZ(CTRL_SZ), .BM_SZ(BM_SZ), .OW(OW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .addr(req_addr), .hit(hit), .off(woff)
  );

  ide_rt_select #(.OW(OW), .BM_SPLIT(BM_SPLIT)) u_sel (
    .clk(clk), .rst_n(rst_n), .hit(hit), .off(woff), .size(req_size),
    .kind(kind), .offset(offset), .sec(sec), .size_err(size_err), .any_hit(any_hit)
  );

  assign err = !any_hit || size_err;

  ide_rt_shadow #(.OW(OW), .SEL_OFF(SEL_OFF)) u_shd (
    .clk(clk), .rst_n(rst_n), .acc_vld(req_vld), .acc_wr(req_wr),
    .acc_kind(kind), .acc_off(offset), .acc_sec(sec), .acc_err(err),
    .dev_bit(req_data[DEV_BIT]), .drive(drive)
  );

  // next state of the response register
  logic          vld_d, sec_d, err_d, ok_d;
  logic [1:0]    type_d, drv_d;
  logic [OW-1:0] off_d;

  always_comb begin
    vld_d  = req_vld;
    type_d = kind;
    off_d  = offset;
    sec_d  = sec;
    err_d  = err;
    drv_d  = drive;
    ok_d   = !err && drv_present[drive];   // R11
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vld <= 1'b0;
    else        rsp_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_type   <= WT_NONE;
      rsp_off    <= '0;
      rsp_sec    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_drive  <= 2'd0;
      rsp_drv_ok <= 1'b0;
    end else if (req_vld) begin
      rsp_type   <= type_d;
      rsp_off    <= off_d;
      rsp_sec    <= sec_d;
      rsp_err    <= err_d;
      rsp_drive  <= drv_d;
      rsp_drv_ok <= ok_d;
    end
  end

  assert_strobe_follows_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld
  );

  assert_strobe_quiet_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld
  );

  assert_miss_is_error_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_type == WT_NONE) |-> (rsp_err && rsp_off == '0 && !rsp_sec)
  );

  assert_bm_channel_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_type == WT_BM) |-> (rsp_sec == (rsp_off >= OW'(BM_SPLIT)))
  );

  assert_drive_channel_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_type != WT_NONE) |-> (rsp_drive[1] == rsp_sec)
  );

  assert_err_not_ok_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_err) |-> !rsp_drv_ok
  );

endmodule

// File: tb/sim_ide_io_router.sv
module sim_ide_io_router;

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  data;
    logic [1:0]  ty;
    logic [3:0]  off;
    logic        sec;
    logic        err;
    logic [1:0]  drv;
  } vec_t;

  localparam int NV = 22;
  // type: 0 cmd, 1 ctrl, 2 bus-master, 3 none; size: 0=1B 1=2B 2=4B 3=bad
  localparam vec_t TBL [NV] = '{
    '{16'h01F0, 1'b0, 2'd0, 8'h00, 2'd0, 4'd0,  1'b0, 1'b0, 2'd0}, // R1 R2
    '{16'h01F7, 1'b0, 2'd1, 8'h00, 2'd0, 4'd7,  1'b0, 1'b0, 2'd0}, // R2
    '{16'h03F6, 1'b0, 2'd0, 8'h00, 2'd1, 4'd2,  1'b0, 1'b0, 2'd0}, // R1
    '{16'h0172, 1'b0, 2'd0, 8'h00, 2'd0, 4'd2,  1'b1, 1'b0, 2'd2}, // R7 R11 (slot 2 absent)
    '{16'h0377, 1'b0, 2'd0, 8'h00, 2'd1, 4'd3,  1'b1, 1'b0, 2'd2}, // R1
    '{16'hC000, 1'b0, 2'd0, 8'h00, 2'd2, 4'd0,  1'b0, 1'b0, 2'd0}, // R3
    '{16'hC007, 1'b0, 2'd0, 8'h00, 2'd2, 4'd7,  1'b0, 1'b0, 2'd0}, // R3 edge
    '{16'hC008, 1'b0, 2'd0, 8'h00, 2'd2, 4'd8,  1'b1, 1'b0, 2'd2}, // R3 edge
    '{16'hC00C, 1'b0, 2'd2, 8'h00, 2'd2, 4'd12, 1'b1, 1'b0, 2'd2}, // R8 4B ok in BM
    '{16'h01F6, 1'b1, 2'd0, 8'h10, 2'd0, 4'd6,  1'b0, 1'b0, 2'd1}, // R6 R7 new bit used
    '{16'h01F0, 1'b0, 2'd0, 8'h00, 2'd0, 4'd0,  1'b0, 1'b0, 2'd1}, // R6
    '{16'h0176, 1'b1, 2'd0, 8'h3A, 2'd0, 4'd6,  1'b1, 1'b0, 2'd3}, // R6
    '{16'hC008, 1'b0, 2'd0, 8'h00, 2'd2, 4'd8,  1'b1, 1'b0, 2'd3}, // R7
    '{16'h01F6, 1'b1, 2'd0, 8'hEF, 2'd0, 4'd6,  1'b0, 1'b0, 2'd0}, // R6 bit4 clear
    '{16'h01F8, 1'b0, 2'd0, 8'h00, 2'd3, 4'd0,  1'b0, 1'b1, 2'd0}, // R4
    '{16'h01F0, 1'b0, 2'd2, 8'h00, 2'd0, 4'd0,  1'b0, 1'b1, 2'd0}, // R8
    '{16'h0176, 1'b1, 2'd2, 8'h00, 2'd0, 4'd6,  1'b1, 1'b1, 2'd3}, // R8 no shadow change
    '{16'h0170, 1'b0, 2'd0, 8'h00, 2'd0, 4'd0,  1'b1, 1'b0, 2'd3}, // R8
    '{16'hC010, 1'b0, 2'd0, 8'h00, 2'd3, 4'd0,  1'b0, 1'b1, 2'd0}, // R4
    '{16'hC000, 1'b0, 2'd3, 8'h00, 2'd2, 4'd0,  1'b0, 1'b1, 2'd0}, // R8 bad code
    '{16'h03F3, 1'b0, 2'd0, 8'h00, 2'd3, 4'd0,  1'b0, 1'b1, 2'd0}, // R4
    '{16'h03F4, 1'b0, 2'd1, 8'h00, 2'd1, 4'd0,  1'b0, 1'b0, 2'd0}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic        req_vld;
  logic [15:0] req_addr;
  logic        req_wr;
  logic [1:0]  req_size;
  logic [7:0]  req_data;
  logic [3:0]  drv_present;
  logic        rsp_vld;
  logic [1:0]  rsp_type;
  logic [3:0]  rsp_off;
  logic        rsp_sec;
  logic        rsp_err;
  logic [1:0]  rsp_drive;
  logic        rsp_drv_ok;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ide_io_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .req_vld(req_vld), .req_addr(req_addr),
    .req_wr(req_wr), .req_size(req_size), .req_data(req_data),
    .drv_present(drv_present), .rsp_vld(rsp_vld), .rsp_type(rsp_type),
    .rsp_off(rsp_off), .rsp_sec(rsp_sec), .rsp_err(rsp_err),
    .rsp_drive(rsp_drive), .rsp_drv_ok(rsp_drv_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [2:0] idx, input logic [15:0] base);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input vec_t v, input string tag);
    logic exp_ok;
    @(negedge clk);
    req_vld = 1'b1; req_addr = v.addr; req_wr = v.wr;
    req_size = v.sz; req_data = v.data;
    @(negedge clk);
    req_vld = 1'b0;
    exp_ok = !v.err && drv_present[v.drv];
    chk({tag, " R9 vld"},    32'(rsp_vld),    32'd1);
    chk({tag, " R1 type"},   32'(rsp_type),   32'(v.ty));
    chk({tag, " R2 off"},    32'(rsp_off),    32'(v.off));
    chk({tag, " R3 sec"},    32'(rsp_sec),    32'(v.sec));
    chk({tag, " R4/R8 err"}, 32'(rsp_err),    32'(v.err));
    chk({tag, " R7 drive"},  32'(rsp_drive),  32'(v.drv));
    chk({tag, " R11 ok"},    32'(rsp_drv_ok), 32'(exp_ok));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0;
    req_vld = 1'b0; req_addr = '0; req_wr = 1'b0; req_size = '0; req_data = '0;
    drv_present = 4'b1011;
    repeat (3) @(negedge clk);
    chk("R12 reset vld", 32'(rsp_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle vld", 32'(rsp_vld), 32'd0);

    // R5: nothing programmed yet -> no window matches
    access('{16'h0000, 1'b0, 2'd0, 8'h00, 2'd3, 4'd0, 1'b0, 1'b1, 2'd0}, "R5 unarmed");

    prog(3'd0, 16'h01F0);
    prog(3'd1, 16'h03F4);
    prog(3'd2, 16'h0170);
    prog(3'd3, 16'h0374);
    prog(3'd4, 16'hC000);

    for (int i = 0; i < NV; i++) access(TBL[i], $sformatf("vec%0d", i));

    // R9: one-cycle strobe
    @(negedge clk);
    chk("R9 strobe drops", 32'(rsp_vld), 32'd0);

    // R5: zero base ignored
    prog(3'd0, 16'h0000);
    access('{16'h01F3, 1'b0, 2'd0, 8'h00, 2'd0, 4'd3, 1'b0, 1'b0, 2'd0}, "R5 zero base");

    // R10: move bus-master window over the first command window
    prog(3'd4, 16'h01F0);
    access('{16'h01F2, 1'b0, 2'd0, 8'h00, 2'd0, 4'd2, 1'b0, 1'b0, 2'd0}, "R10 overlap cmd wins");
    access('{16'h01F9, 1'b0, 2'd0, 8'h00, 2'd2, 4'd9, 1'b1, 1'b0, 2'd3}, "R10 bm tail");

    // R11: populate slot 2 and check ok follows the mask
    drv_present = 4'b0100;
    prog(3'd4, 16'hC000);
    access('{16'h0176, 1'b1, 2'd0, 8'h00, 2'd0, 4'd6, 1'b1, 1'b0, 2'd2}, "R11 slot2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule